// File: doc/BRIEF.md
# Soft-reset and clock-gate controller

This block holds one 32-bit control word for a peripheral. The top bit of the word requests a soft reset of the peripheral, and the next bit gates its clock. The controller drives a block-wide reset output and a clock-enable output from these two bits. The clock gate is modelled as an enable, not as a gating cell.

Software reaches the word through a small register port. The port has three addresses. One address writes the whole word. A set alias ORs a mask into the word. A clear alias removes the bits of a mask from the word. With the aliases, software changes single bits without a read-modify-write.

When the soft-reset bit becomes 1, the controller gates the clock by itself after a fixed number of cycles. It keeps the clock gated for as long as the reset bit stays 1. After software clears the reset bit, the gate stays closed until software clears it. While the peripheral is held in reset, the remaining configuration bits stay at zero.

Top module: `srst_gate_ctrl`

## Requirements
- R1: After `rst_n` is released, the control word reads 0x0000_0000, `blk_rst_o` is 0 and `clk_en_o` is 1.
- R2: A write to offset 0x0 loads the whole word. Reads at offsets 0x0, 0x4 and 0x8 return the word. Any other offset reads 0, and a write to it changes nothing.
- R3: A write to the set alias at offset 0x4 sets exactly the bits that are 1 in the data and leaves the other bits unchanged.
- R4: A write to the clear alias at offset 0x8 clears exactly the bits that are 1 in the data and leaves the other bits unchanged.
- R5: Bit 31 is the soft-reset bit and drives `blk_rst_o`. Bit 30 is the clock-gate bit, and `clk_en_o` is its inverse. Both outputs follow the word in the cycle after the write.
- R6: Suppose bit 31 becomes 1 at a clock edge. Then bit 30 reads 1 exactly GATE_DELAY cycles later, with no write. If bit 31 is cleared before then, bit 30 is not forced.
- R7: While bit 31 is 1, bits 29:0 read 0 and writes to them are ignored. A write that sets bit 31 also clears bits 29:0.
- R8: After bit 31 is cleared, it reads back 0 in the next cycle. Bit 30 stays 1 until software clears it, and `clk_en_o` then returns to 1.
- R9: Once the gate delay has expired and bit 31 is still 1, a software clear of bit 30 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data or mask |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| blk_rst_o | output | 1 | Reset to the downstream peripheral |
| clk_en_o | output | 1 | Clock enable to the downstream peripheral |
| cfg_o | output | 30 | Configuration bits 29:0 of the word |

## Verification
The assertions assume that `bus_we` is a clean one-cycle strobe and that `bus_addr` and `bus_wdata` are stable around the edge that samples the strobe. The bench drives every input on the falling clock edge and holds the write strobe for exactly one rising edge, so these assumptions hold. The gate-window assertion also assumes that nothing sets bit 30 by way of a full-word write while the reset bit is rising. The stimulus uses only the set and clear aliases to assert and release soft reset.

// File: rtl/srgc_pkg.sv
package srgc_pkg;

  localparam int SRST_BIT = 31;
  localparam int GATE_BIT = 30;
  localparam int CFG_W    = 30;

  localparam logic [31:0] OFS_FULL = 32'h0;
  localparam logic [31:0] OFS_SET  = 32'h4;
  localparam logic [31:0] OFS_CLR  = 32'h8;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_FULL = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } wr_op_e;

  // Value of the word after one software access, hardware effects not included
  function automatic logic [31:0] apply_write(wr_op_e op, logic [31:0] cur,
                                              logic [31:0] data);
    case (op)
      OP_FULL: apply_write = data;
      OP_SET:  apply_write = cur | data;
      OP_CLR:  apply_write = cur & ~data;
      default: apply_write = cur;
    endcase
  endfunction

  // Combine the software result with the hardware gate force and the reset hold
  function automatic logic [31:0] next_ctrl(logic [31:0] cur, logic [31:0] sw,
                                            logic force_gate);
    logic [31:0] n;
    n[SRST_BIT] = sw[SRST_BIT];
    n[GATE_BIT] = sw[GATE_BIT] | force_gate;
    n[CFG_W-1:0] = (sw[SRST_BIT] || cur[SRST_BIT]) ? '0 : sw[CFG_W-1:0];
    next_ctrl = n;
  endfunction

endpackage

// File: rtl/srgc_addr_dec.sv
module srgc_addr_dec
  import srgc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output wr_op_e            op,
  output logic              rd_hit
);

  localparam logic [ADDR_W-1:0] A_FULL = ADDR_W'(OFS_FULL);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);

  always_comb begin
    if (addr == A_FULL)     op = OP_FULL;
    else if (addr == A_SET) op = OP_SET;
    else if (addr == A_CLR) op = OP_CLR;
    else                    op = OP_NONE;
  end

  assign rd_hit = (op != OP_NONE);

endmodule

// File: rtl/srgc_gate_timer.sv
module srgc_gate_timer #(
  parameter int GATE_DELAY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_q,
  output logic gate_force
);

  localparam int CNT_W = (GATE_DELAY > 1) ? $clog2(GATE_DELAY) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GATE_DELAY - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             expired;

  assign expired    = (cnt_q == CNT_LAST);
  assign gate_force = srst_q && expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!srst_q)    cnt_q <= '0;
    else if (!expired)   cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/srst_gate_ctrl.sv
module srst_gate_ctrl
  import srgc_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int GATE_DELAY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              blk_rst_o,
  output logic              clk_en_o,
  output logic [CFG_W-1:0]  cfg_o
);

  logic [31:0] ctrl_q;
  logic [31:0] sw_val;
  logic [31:0] ctrl_d;
  wr_op_e      wr_op;
  logic        rd_hit;
  logic        gate_force;

  srgc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .op     (wr_op),
    .rd_hit (rd_hit)
  );

  srgc_gate_timer #(.GATE_DELAY(GATE_DELAY)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .srst_q     (ctrl_q[SRST_BIT]),
    .gate_force (gate_force)
  );

  assign sw_val = bus_we ? apply_write(wr_op, ctrl_q, bus_wdata) : ctrl_q;
  assign ctrl_d = next_ctrl(ctrl_q, sw_val, gate_force);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign bus_rdata = rd_hit ? ctrl_q : '0;
  assign blk_rst_o = ctrl_q[SRST_BIT];
  assign clk_en_o  = ~ctrl_q[GATE_BIT];
  assign cfg_o     = ctrl_q[CFG_W-1:0];

endmodule

// File: rtl/srgc_chk.sv
module srgc_chk
  import srgc_pkg::*;
#(
  parameter int GATE_DELAY = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        we,
  input wr_op_e      op,
  input logic [31:0] wdata,
  input logic [31:0] ctrl,
  input logic        gate_force
);

  logic [15:0] wait_cnt;
  logic        gate_clr_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  wait_cnt <= '0;
    else if (ctrl[SRST_BIT] && !ctrl[GATE_BIT])  wait_cnt <= (wait_cnt == 16'hFFFF) ? wait_cnt : wait_cnt + 1'b1;
    else                                         wait_cnt <= '0;
  end

  assign gate_clr_wr = we && ((op == OP_FULL && !wdata[GATE_BIT]) ||
                              (op == OP_CLR && wdata[GATE_BIT]));

  assert_set_srst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && op == OP_SET && wdata[SRST_BIT]) |=> ctrl[SRST_BIT]);

  assert_clr_srst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && op == OP_CLR && wdata[SRST_BIT]) |=> !ctrl[SRST_BIT]);

  assert_unmapped_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && op == OP_NONE && !gate_force) |=> (ctrl == $past(ctrl)));

  assert_gate_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[SRST_BIT] && !ctrl[GATE_BIT]) |-> (wait_cnt < 16'(GATE_DELAY)));

  assert_cfg_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[SRST_BIT] |-> (ctrl[CFG_W-1:0] == '0));

  assert_gate_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[GATE_BIT] && !gate_clr_wr) |=> ctrl[GATE_BIT]);

  assert_force_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gate_force |=> ctrl[GATE_BIT]);

endmodule

bind srst_gate_ctrl srgc_chk #(.GATE_DELAY(GATE_DELAY)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .we         (bus_we),
  .op         (wr_op),
  .wdata      (bus_wdata),
  .ctrl       (ctrl_q),
  .gate_force (gate_force)
);

// File: tb/srst_gate_ctrl_tb.sv
module srst_gate_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;
  localparam int GATE_DELAY = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              blk_rst_o;
  logic              clk_en_o;
  logic [29:0]       cfg_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  srst_gate_ctrl #(.ADDR_W(ADDR_W), .GATE_DELAY(GATE_DELAY)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .blk_rst_o(blk_rst_o),
    .clk_en_o(clk_en_o), .cfg_o(cfg_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one-cycle write; returns 1ns after the edge that samples it
  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'h0, v);
    chk("R1 word", v, 32'h0);
    chk("R1 blk_rst", 32'(blk_rst_o), 32'h0);
    chk("R1 clk_en", 32'(clk_en_o), 32'h1);
  endtask

  task automatic t_full_and_alias();
    logic [31:0] v;
    wr(4'h0, 32'h0000_1234);
    rd(4'h0, v); chk("R2 full write", v, 32'h0000_1234);
    rd(4'h4, v); chk("R2 read at set alias", v, 32'h0000_1234);
    rd(4'h8, v); chk("R2 read at clr alias", v, 32'h0000_1234);
    rd(4'hC, v); chk("R2 unmapped read", v, 32'h0);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h0, v); chk("R2 unmapped write ignored", v, 32'h0000_1234);
    chk("R2 cfg_o", 32'(cfg_o), 32'h0000_1234);
    wr(4'h4, 32'h00F0_0000);
    rd(4'h0, v); chk("R3 set mask", v, 32'h00F0_1234);
    wr(4'h8, 32'h0000_0204);
    rd(4'h0, v); chk("R4 clr mask", v, 32'h00F0_1030);
  endtask

  task automatic t_gate_direct();
    wr(4'h4, 32'h4000_0000);
    chk("R5 gate set clk_en", 32'(clk_en_o), 32'h0);
    chk("R5 blk_rst idle", 32'(blk_rst_o), 32'h0);
    wr(4'h8, 32'h4000_0000);
    chk("R5 gate clear clk_en", 32'(clk_en_o), 32'h1);
  endtask

  task automatic t_soft_reset();
    logic [31:0] v;
    wr(4'h4, 32'h8000_0000);
    chk("R5 blk_rst asserted", 32'(blk_rst_o), 32'h1);
    rd(4'h0, v); chk("R7 cfg cleared on entry", v, 32'h8000_0000);
    for (int k = 1; k <= GATE_DELAY; k++) begin
      @(posedge clk); #1;
      chk($sformatf("R6 gate at +%0d", k), 32'(clk_en_o), (k == GATE_DELAY) ? 32'h0 : 32'h1);
    end
    wr(4'h4, 32'h0000_00FF);
    rd(4'h0, v); chk("R7 cfg write ignored", v, 32'hC000_0000);
    wr(4'h8, 32'h4000_0000);
    rd(4'h0, v); chk("R9 gate clear loses to force", v, 32'hC000_0000);
    wr(4'h8, 32'h8000_0000);
    rd(4'h0, v); chk("R8 srst reads 0, gate kept", v, 32'h4000_0000);
    chk("R8 clk still gated", 32'(clk_en_o), 32'h0);
    wr(4'h4, 32'h0000_0005);
    rd(4'h0, v); chk("R7 cfg writable after release", v, 32'h4000_0005);
    wr(4'h8, 32'h4000_0000);
    chk("R8 clk_en after ungate", 32'(clk_en_o), 32'h1);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    wr(4'h0, 32'h0);
    wr(4'h4, 32'h8000_0000);
    wr(4'h8, 32'h8000_0000);
    repeat (GATE_DELAY + 2) @(posedge clk);
    #1;
    rd(4'h0, v); chk("R6 early release no gate", v, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_and_alias();
    t_gate_direct();
    t_soft_reset();
    t_abort();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule